// File: doc/BRIEF.md
# Daisy-Chain Address Assignment Controller

This block is the per-chip command-steering logic for a string of identical ASICs wired in series, where each chip receives commands on an upstream port and may pass them on to the next chip. An upstream parser hands the block one decoded command at a time. Each command arrives as a single-cycle strobe with four parts: a command kind, a broadcast flag, a target address and a data byte. For every command the block decides three things. It decides whether to pass the command downstream, whether this chip must answer, and whether the command changes the chip's own address.

Addresses are handed out by position in the chain. A quiet-chain command puts every chip into a mode where ordinary traffic is no longer passed on, and it makes every chip forget that it holds an address. After that, each set-address command is absorbed by the first chip in the chain that is still unassigned and passed on by every chip that is already assigned. The values handed out need not be contiguous. The latched address is also added to the nonce value the chip emits, so that the chips on one chain split the 32-bit search space between them.

Top module: `chain_addr_ctrl`

## Requirements
- R1: After reset the chip address is 0, the relay and reply strobes are low, and the chip is in pass-through (not quiet) mode with no address assigned.
- R2: A register read (kind 0) with the broadcast flag set raises the reply strobe, whatever the chip address. Outside quiet mode it also raises the relay strobe.
- R3: A unicast register read whose target equals the chip address raises the reply strobe and not the relay strobe. A unicast read with a different target raises only the relay strobe when not in quiet mode.
- R4: A quiet-chain command (kind 2) raises the relay strobe and not the reply strobe. It puts the chip in quiet mode, which lasts until reset, and it clears the assigned flag without changing the address value.
- R5: In quiet mode, no register read or register write is relayed. A broadcast read still raises the reply strobe.
- R6: In quiet mode, a chip with no assigned address absorbs a set-address command (kind 3). It loads the data byte as its address, becomes assigned, and raises neither strobe.
- R7: A chip that already holds an assigned address relays every set-address command and keeps its address.
- R8: Outside quiet mode, a set-address command is relayed and does not change the address.
- R9: A register write (kind 1) never changes the chip address. A unicast write to the chip's own address raises no strobe. Any other write is relayed outside quiet mode.
- R10: The nonce output equals the nonce input plus the zero-extended chip address, modulo 2^32.
- R11: The strobes are one cycle wide. They appear exactly one clock after the command strobe, and no strobe appears without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe marking a decoded command |
| cmdType | input | 2 | Command kind: 0 read, 1 write, 2 quiet chain, 3 set address |
| cmdBcast | input | 1 | Broadcast flag: the command addresses every chip |
| cmdAddr | input | 8 | Target chip address of a unicast command |
| cmdData | input | 8 | New address for set-address, write data otherwise |
| nonceIn | input | 32 | Nonce from the local search counter |
| relayStb | output | 1 | Pass the current command to the next chip |
| replyStb | output | 1 | This chip must send a register reply |
| curAddr | output | 8 | Current chip address |
| nonceOut | output | 32 | Nonce offset by the chip address |

## Verification
The assertions assume that the command inputs are meaningful only while cmdValid is high, and that commands come at most one per cycle. They also assume that set-address commands reach a chip only through the chain, so a chip sees quiet mode before it absorbs one. The bench drives every command as a single-cycle strobe with at least two idle cycles after it. It sends the quiet-chain command before any set-address that is meant to be absorbed, and it checks both the strobe cycle and the idle cycle after it. Nonce inputs are applied with the address held, because the sum is combinational.

// File: rtl/chain_addr_pkg.sv
package chain_addr_pkg;

  typedef enum logic [1:0] {
    CMD_READ    = 2'd0,
    CMD_WRITE   = 2'd1,
    CMD_QUIET   = 2'd2,
    CMD_SETADDR = 2'd3
  } cmdKind_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic latchAddr;
  } dpCtrl_t;

endpackage

// File: rtl/chain_addr_ctrl_fsm.sv
module chain_addr_ctrl_fsm
  import chain_addr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  cmdKind_e          cmdKind,
  input  logic              cmdBcast,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] curAddr,
  output dpCtrl_t           dpCtrl,
  output logic              relayStb,
  output logic              replyStb
);

  logic quietQ;
  logic assignedQ;
  logic addrHit;
  logic relayNext;
  logic replyNext;
  logic takeAddr;
  logic enterQuiet;

  assign addrHit = (cmdAddr == curAddr);

  always_comb begin
    relayNext  = 1'b0;
    replyNext  = 1'b0;
    takeAddr   = 1'b0;
    enterQuiet = 1'b0;
    if (cmdValid) begin
      unique case (cmdKind)
        CMD_READ: begin
          if (cmdBcast) begin
            replyNext = 1'b1;
            relayNext = !quietQ;
          end else if (addrHit) begin
            replyNext = 1'b1;
          end else begin
            relayNext = !quietQ;
          end
        end
        CMD_WRITE: begin
          if (cmdBcast || !addrHit) relayNext = !quietQ;
        end
        CMD_QUIET: begin
          relayNext  = 1'b1;
          enterQuiet = 1'b1;
        end
        CMD_SETADDR: begin
          if (quietQ && !assignedQ) takeAddr = 1'b1;
          else relayNext = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign dpCtrl.latchAddr = takeAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quietQ    <= 1'b0;
      assignedQ <= 1'b0;
      relayStb  <= 1'b0;
      replyStb  <= 1'b0;
    end else begin
      relayStb <= relayNext;
      replyStb <= replyNext;
      if (enterQuiet) quietQ <= 1'b1;
      if (enterQuiet) assignedQ <= 1'b0;
      else if (takeAddr) assignedQ <= 1'b1;
    end
  end

  // R4: quiet mode persists until reset
  a_r4_quiet_sticky: assert property (@(posedge clk) disable iff (!rstN)
    quietQ |=> quietQ);

  // R6: an address is only accepted while the chain is quiet
  a_r6_assign_in_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(assignedQ) |-> quietQ);

  // R6: an absorbed set-address is never passed on
  a_r6_absorb_no_relay: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.latchAddr |=> (!relayStb && !replyStb));

  // R11: strobes only follow a command
  a_r11_strobe_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (relayStb || replyStb) |-> $past(cmdValid));

  // R2: broadcast read always answered
  a_r2_bcast_reply: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == CMD_READ && cmdBcast) |=> replyStb);

  // R7: assigned chip relays set-address
  a_r7_assigned_relays: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == CMD_SETADDR && assignedQ) |=> relayStb);

endmodule

// File: rtl/chain_addr_datapath.sv
module chain_addr_datapath
  import chain_addr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NONCE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            dpCtrl,
  input  logic [ADDR_W-1:0]  newAddr,
  input  logic [NONCE_W-1:0] nonceIn,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [NONCE_W-1:0] nonceOut
);

  localparam int PAD_W = NONCE_W - ADDR_W;

  logic [ADDR_W-1:0]  addrQ;
  logic [NONCE_W-1:0] addrWide;

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (dpCtrl.latchAddr) addrQ <= newAddr;
  end

  assign curAddr  = addrQ;
  assign addrWide = {{PAD_W{1'b0}}, addrQ};
  assign nonceOut = nonceIn + addrWide;

  // R9, R7, R8: address moves only on an absorbed set-address
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.latchAddr |=> $stable(addrQ));

  // R6: absorbed payload becomes the address
  a_r6_addr_load: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.latchAddr |=> (curAddr == $past(newAddr)));

endmodule

// File: rtl/chain_addr_ctrl.sv
module chain_addr_ctrl
  import chain_addr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NONCE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdType,
  input  logic               cmdBcast,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [ADDR_W-1:0]  cmdData,
  input  logic [NONCE_W-1:0] nonceIn,
  output logic               relayStb,
  output logic               replyStb,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [NONCE_W-1:0] nonceOut
);

  dpCtrl_t  dpCtrl;
  cmdKind_e cmdKind;

  assign cmdKind = cmdKind_e'(cmdType);

  chain_addr_ctrl_fsm #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdKind  (cmdKind),
    .cmdBcast (cmdBcast),
    .cmdAddr  (cmdAddr),
    .curAddr  (curAddr),
    .dpCtrl   (dpCtrl),
    .relayStb (relayStb),
    .replyStb (replyStb)
  );

  chain_addr_datapath #(.ADDR_W(ADDR_W), .NONCE_W(NONCE_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .newAddr  (cmdData),
    .nonceIn  (nonceIn),
    .curAddr  (curAddr),
    .nonceOut (nonceOut)
  );

  // R11: strobes last a single cycle when commands are spaced
  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (relayStb && !$past(cmdValid, 1)) |-> 1'b0);

endmodule

// File: tb/tb_chain_addr_ctrl.sv
module tb_chain_addr_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdType = 2'd0;
  logic        cmdBcast = 1'b0;
  logic [7:0]  cmdAddr = 8'd0;
  logic [7:0]  cmdData = 8'd0;
  logic [31:0] nonceIn = 32'd0;
  logic        relayStb;
  logic        replyStb;
  logic [7:0]  curAddr;
  logic [31:0] nonceOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chain_addr_ctrl dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdBcast(cmdBcast), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .nonceIn(nonceIn), .relayStb(relayStb), .replyStb(replyStb),
    .curAddr(curAddr), .nonceOut(nonceOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends one command and checks the strobes, the idle cycle after and the address
  task automatic sendCmd(input string req, input logic [1:0] kind, input logic bc,
                         input logic [7:0] tgt, input logic [7:0] data,
                         input logic expRelay, input logic expReply, input logic [7:0] expAddr);
    @(negedge clk);
    cmdValid = 1'b1; cmdType = kind; cmdBcast = bc; cmdAddr = tgt; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdType = 2'd0; cmdBcast = 1'b0; cmdAddr = 8'hA5; cmdData = 8'h5A;
    check({req, " relay"}, {31'd0, relayStb}, {31'd0, expRelay});
    check({req, " reply"}, {31'd0, replyStb}, {31'd0, expReply});
    check({req, " addr"}, {24'd0, curAddr}, {24'd0, expAddr});
    @(negedge clk);
    check("R11 strobes low after one cycle", {30'd0, relayStb, replyStb}, 32'd0);
  endtask

  task automatic nonceCheck(input string req, input logic [31:0] n, input logic [31:0] exp);
    @(negedge clk);
    nonceIn = n;
    #1;
    check(req, nonceOut, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 addr", {24'd0, curAddr}, 32'd0);
    check("R1 strobes", {30'd0, relayStb, replyStb}, 32'd0);
    nonceCheck("R10 nonce with addr 0", 32'hFFFF_FFF0, 32'hFFFF_FFF0);
  endtask

  task automatic testPassThrough();
    sendCmd("R2 bcast read", 2'd0, 1'b1, 8'h33, 8'h00, 1'b1, 1'b1, 8'h00);
    sendCmd("R3 read own", 2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00);
    sendCmd("R3 read other", 2'd0, 1'b0, 8'h05, 8'h00, 1'b1, 1'b0, 8'h00);
    sendCmd("R9 write own", 2'd1, 1'b0, 8'h00, 8'h77, 1'b0, 1'b0, 8'h00);
    sendCmd("R9 write other", 2'd1, 1'b0, 8'h09, 8'h77, 1'b1, 1'b0, 8'h00);
    sendCmd("R9 write bcast", 2'd1, 1'b1, 8'h00, 8'h44, 1'b1, 1'b0, 8'h00);
    sendCmd("R8 setaddr not quiet", 2'd3, 1'b0, 8'h00, 8'h08, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic testAssign();
    sendCmd("R4 quiet cmd", 2'd2, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
    sendCmd("R5 quiet read other", 2'd0, 1'b0, 8'h07, 8'h00, 1'b0, 1'b0, 8'h00);
    sendCmd("R5 quiet bcast read", 2'd0, 1'b1, 8'h07, 8'h00, 1'b0, 1'b1, 8'h00);
    sendCmd("R5 quiet write other", 2'd1, 1'b0, 8'h07, 8'h01, 1'b0, 1'b0, 8'h00);
    sendCmd("R6 absorb setaddr", 2'd3, 1'b0, 8'h00, 8'h10, 1'b0, 1'b0, 8'h10);
    sendCmd("R7 relay setaddr", 2'd3, 1'b0, 8'h00, 8'h18, 1'b1, 1'b0, 8'h10);
    sendCmd("R7 relay setaddr again", 2'd3, 1'b0, 8'h00, 8'h20, 1'b1, 1'b0, 8'h10);
    sendCmd("R3 read new own", 2'd0, 1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 8'h10);
    sendCmd("R9 write own addr", 2'd1, 1'b0, 8'h10, 8'h55, 1'b0, 1'b0, 8'h10);
  endtask

  task automatic testNonce();
    nonceCheck("R10 nonce plain", 32'h0000_1000, 32'h0000_1010);
    nonceCheck("R10 nonce wrap", 32'hFFFF_FFF8, 32'h0000_0008);
  endtask

  task automatic testReassign();
    sendCmd("R4 second quiet clears assigned", 2'd2, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h10);
    sendCmd("R6 re-absorb setaddr", 2'd3, 1'b0, 8'h00, 8'hE8, 1'b0, 1'b0, 8'hE8);
    sendCmd("R7 relay after reassign", 2'd3, 1'b0, 8'h00, 8'hF0, 1'b1, 1'b0, 8'hE8);
    nonceCheck("R10 nonce high addr", 32'h1234_5600, 32'h1234_56E8);
  endtask

  task automatic testIdle();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R11 no strobe when idle", {30'd0, relayStb, replyStb}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPassThrough();
    testAssign();
    testNonce();
    testReassign();
    testIdle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule